// File: doc/BRIEF.md
# Register Rename Table with Free List

This block renames the destination and source registers of instructions as they enter an out-of-order window in program order. For every architectural register it keeps a valid flag and the physical tag of the most recent in-flight writer. When the flag is clear, a consumer reads the committed value from a separate architectural register file outside this block. Physical tags are handed out from a FIFO free list. A ready bit per physical register records whether that register's result has been written back.

Each cycle, at most one instruction is offered for allocation. The block answers at once with the location of both sources and the tag for the destination. Execution units report finished results on a writeback port. The commit port returns a tag to the free list when its instruction retires. A flush after a mispredicted branch drops every speculative mapping and refills the free list, because at that point no in-flight consumer remains.

Top module: `reg_rename`

## Requirements
- R1: After reset every architectural register reads as not renamed. The free list holds all tags in ascending order, so the first destination tags handed out are 0, 1, 2 and so on.
- R2: A granted allocation with a destination takes the tag at the head of the free list (shown on `dst_tag`). From the next cycle, that destination register maps to this tag and the tag's ready bit is 0.
- R3: `srcN_renamed` is 1 exactly when the source register has an in-flight writer. In that case `srcN_tag` is the tag of the youngest such writer. When `srcN_renamed` is 0, the operand comes from the architectural file.
- R4: When a source names the same register as the destination of the same instruction, the source sees the mapping from before that instruction.
- R5: `alloc_grant` is 0 when `alloc_has_dst` is 1 and the free list is empty, and also during a flush. An allocation without a destination is granted whenever the free list is empty but no flush is present. A refused allocation changes no state.
- R6: A writeback of a tag sets its ready bit, which `srcN_ready` shows from the next cycle.
- R7: A commit appends its tag to the tail of the free list, so freed tags are handed out again in commit order after the tags already waiting. The free list never holds more than its capacity.
- R8: A commit clears the mapping of its architectural register only when that mapping still holds the committed tag. A younger mapping is kept.
- R9: A flush makes every register read as not renamed from the next cycle, and restores the free list to its reset contents and order.
- R10: When an allocation and a commit name the same architectural register in one cycle, the new mapping from the allocation is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all speculative mappings and refill the free list |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_has_dst | input | 1 | The offered instruction writes a register |
| alloc_src1 | input | 3 | First source architectural register |
| alloc_src2 | input | 3 | Second source architectural register |
| alloc_dst | input | 3 | Destination architectural register |
| alloc_grant | output | 1 | The allocation is accepted this cycle |
| dst_tag | output | 5 | Physical tag for the destination (head of free list) |
| src1_renamed | output | 1 | First source has an in-flight writer |
| src1_tag | output | 5 | Physical tag of the first source |
| src1_ready | output | 1 | Ready bit of `src1_tag` |
| src2_renamed | output | 1 | Second source has an in-flight writer |
| src2_tag | output | 5 | Physical tag of the second source |
| src2_ready | output | 1 | Ready bit of `src2_tag` |
| wb_valid | input | 1 | A result is written back |
| wb_tag | input | 5 | Tag of the written-back result |
| cm_valid | input | 1 | The oldest writing instruction commits |
| cm_arch | input | 3 | Architectural destination of the committing instruction |
| cm_tag | input | 5 | Physical tag of the committing instruction |

## Verification
The assertions assume that the surrounding pipeline follows the protocol. A written-back tag must belong to an in-flight instruction, so it can never equal the free-list head being allocated. A commit must return a tag that is in flight, which keeps the free list from overflowing. The stimulus keeps within these limits by tracking the in-flight instructions in program order. It commits only the oldest one, with its own register and tag, and it writes back only tags from that in-flight set. The in-flight set is cleared on every flush.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_valid,
  input  logic          alloc_has_dst,
  input  logic [AW-1:0] alloc_src1,
  input  logic [AW-1:0] alloc_src2,
  input  logic [AW-1:0] alloc_dst,
  output logic          alloc_grant,
  output logic [PW-1:0] dst_tag,
  output logic          src1_renamed,
  output logic [PW-1:0] src1_tag,
  output logic          src1_ready,
  output logic          src2_renamed,
  output logic [PW-1:0] src2_tag,
  output logic          src2_ready,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_tag,
  input  logic          cm_valid,
  input  logic [AW-1:0] cm_arch,
  input  logic [PW-1:0] cm_tag
);

  logic [NUM_ARCH-1:0] map_vld;
  logic [PW-1:0]       map_tag [NUM_ARCH];
  logic [NUM_PHYS-1:0] rdy;
  logic [PW-1:0]       fl_mem [NUM_PHYS];
  logic [PW-1:0]       fl_head, fl_tail;
  logic [CW-1:0]       fl_count;

  logic take, give, stale;

  assign alloc_grant = alloc_valid && !flush && (!alloc_has_dst || fl_count != '0);
  assign take        = alloc_grant && alloc_has_dst;
  assign give        = cm_valid && !flush;
  assign stale       = map_vld[cm_arch] && map_tag[cm_arch] == cm_tag;
  assign dst_tag     = fl_mem[fl_head];

  assign src1_renamed = map_vld[alloc_src1];
  assign src1_tag     = map_tag[alloc_src1];
  assign src1_ready   = rdy[src1_tag];
  assign src2_renamed = map_vld[alloc_src2];
  assign src2_tag     = map_tag[alloc_src2];
  assign src2_ready   = rdy[src2_tag];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld  <= '0;
      rdy      <= '0;
      fl_head  <= '0;
      fl_tail  <= '0;
      fl_count <= CW'(NUM_PHYS);
      for (int i = 0; i < NUM_ARCH; i++) map_tag[i] <= '0;
      for (int i = 0; i < NUM_PHYS; i++) fl_mem[i] <= PW'(i);
    end else if (flush) begin
      map_vld  <= '0;
      fl_head  <= '0;
      fl_tail  <= '0;
      fl_count <= CW'(NUM_PHYS);
      for (int i = 0; i < NUM_PHYS; i++) fl_mem[i] <= PW'(i);
      if (wb_valid) rdy[wb_tag] <= 1'b1;
    end else begin
      if (give && stale) map_vld[cm_arch] <= 1'b0;
      if (take) begin
        map_vld[alloc_dst] <= 1'b1;
        map_tag[alloc_dst] <= dst_tag;
      end
      if (wb_valid) rdy[wb_tag] <= 1'b1;
      if (take) rdy[dst_tag] <= 1'b0;
      if (give) begin
        fl_mem[fl_tail] <= cm_tag;
        fl_tail         <= bump(fl_tail);
      end
      if (take) fl_head <= bump(fl_head);
      fl_count <= fl_count + CW'(give) - CW'(take);
    end
  end

endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int NUM_PHYS = 32,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                alloc_valid,
  input logic                alloc_has_dst,
  input logic                alloc_grant,
  input logic [PW-1:0]       dst_tag,
  input logic                wb_valid,
  input logic [PW-1:0]       wb_tag,
  input logic                cm_valid,
  input logic [CW-1:0]       fl_count,
  input logic [NUM_PHYS-1:0] rdy
);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= CW'(NUM_PHYS));

  assert_stall_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_has_dst && fl_count == '0) |-> !alloc_grant);

  assert_flush_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fl_count == CW'(NUM_PHYS));

  assert_fresh_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_grant && alloc_has_dst) |=> !rdy[$past(dst_tag)]);

  assert_wb_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(alloc_grant && alloc_has_dst && dst_tag == wb_tag)) |=> rdy[$past(wb_tag)]);

  assert_commit_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush && !(alloc_grant && alloc_has_dst)) |=> fl_count == $past(fl_count) + 1'b1);

endmodule

bind reg_rename reg_rename_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
  .alloc_has_dst(alloc_has_dst), .alloc_grant(alloc_grant), .dst_tag(dst_tag),
  .wb_valid(wb_valid), .wb_tag(wb_tag), .cm_valid(cm_valid),
  .fl_count(fl_count), .rdy(rdy)
);

// File: tb/reg_rename_bench.sv
`timescale 1ns/1ps
module reg_rename_bench;
  logic clk = 0, rst_n = 0;
  logic flush = 0, alloc_valid = 0, alloc_has_dst = 0;
  logic [2:0] alloc_src1 = 0, alloc_src2 = 0, alloc_dst = 0, cm_arch = 0;
  logic wb_valid = 0, cm_valid = 0;
  logic [4:0] wb_tag = 0, cm_tag = 0;
  logic alloc_grant, src1_renamed, src1_ready, src2_renamed, src2_ready;
  logic [4:0] dst_tag, src1_tag, src2_tag;

  int n_chk = 0, n_fail = 0;
  bit mv [8];
  int mt [8];
  bit mrdy [32];
  int fq [$];
  int inf_arch [$];
  int inf_tag [$];

  always #2.5 clk = ~clk;

  reg_rename u_reg_rename (.*);

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit exp_grant(bit f, bit av, bit hd);
    return av && !f && (!hd || fq.size() > 0);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mv[i] = 0;
    fq.delete(); inf_arch.delete(); inf_tag.delete();
    for (int i = 0; i < 32; i++) fq.push_back(i);
  endtask

  task automatic step(bit f, bit av, bit hd, int s1, int s2, int d,
                      bit wv, int wt, bit cv, string lab);
    string ls, lg, ld;
    bit g;
    @(negedge clk);
    if (cv && inf_tag.size() == 0) cv = 0;
    flush = f; alloc_valid = av; alloc_has_dst = hd;
    alloc_src1 = 3'(s1); alloc_src2 = 3'(s2); alloc_dst = 3'(d);
    wb_valid = wv; wb_tag = 5'(wt); cm_valid = cv;
    cm_arch = cv ? 3'(inf_arch[0]) : 3'd0;
    cm_tag  = cv ? 5'(inf_tag[0]) : 5'd0;
    #1;
    ls = (lab != "") ? lab : ((av && hd && (s1 == d || s2 == d)) ? "R4" : "R3");
    lg = (lab != "") ? lab : "R5";
    ld = (lab != "") ? lab : "R2";
    g = exp_grant(f, av, hd);
    chk(lg, alloc_grant, g);
    if (fq.size() > 0) chk(ld, dst_tag, fq[0]);
    chk(ls, src1_renamed, mv[s1]);
    chk(ls, src2_renamed, mv[s2]);
    if (mv[s1]) begin chk(ls, src1_tag, mt[s1]); chk((lab != "") ? lab : "R6", src1_ready, mrdy[mt[s1]]); end
    if (mv[s2]) begin chk(ls, src2_tag, mt[s2]); chk((lab != "") ? lab : "R6", src2_ready, mrdy[mt[s2]]); end
    @(posedge clk);
    if (wv) mrdy[wt] = 1;
    if (f) model_reset();
    else begin
      int t;
      if (cv) begin
        int ca = inf_arch.pop_front();
        int ct = inf_tag.pop_front();
        if (mv[ca] && mt[ca] == ct) mv[ca] = 0;
        fq.push_back(ct);
      end
      if (g && hd) begin
        t = fq.pop_front();
        mv[d] = 1; mt[d] = t; mrdy[t] = 0;
        inf_arch.push_back(d); inf_tag.push_back(t);
      end
    end
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mrdy[i] = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", dst_tag, 0);
    for (int a = 0; a < 8; a++) begin
      alloc_src1 = 3'(a); #0.1;
      chk("R1", src1_renamed, 0);
    end
    step(0, 1, 1, 1, 2, 1, 0, 0, 0, "");
    step(0, 1, 1, 1, 1, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    step(0, 1, 0, 1, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, "");
    step(0, 1, 0, 1, 1, 0, 0, 0, 0, "R6");
    step(0, 1, 1, 0, 0, 1, 0, 0, 1, "");
    step(0, 1, 0, 1, 0, 0, 0, 0, 0, "R10");
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 1, 2, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 32; i++) step(0, 1, 1, i % 8, 0, i % 8, 0, 0, 0, "");
    step(0, 1, 1, 3, 4, 5, 0, 0, 0, "R5");
    step(0, 1, 0, 3, 4, 5, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    step(0, 1, 1, 0, 0, 6, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    for (int c = 0; c < 4000; c++) begin
      bit f  = ($urandom % 100) < 2;
      bit av = ($urandom % 100) < 70;
      bit hd = ($urandom % 100) < 80;
      bit wv = 0, cv;
      int wt = 0;
      if (inf_tag.size() > 0 && ($urandom % 100) < 50) begin
        wv = 1; wt = inf_tag[$urandom % inf_tag.size()];
      end
      cv = ($urandom % 100) < 30;
      step(f, av, hd, $urandom % 8, $urandom % 8, $urandom % 8, wv, wt, cv, "");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule